// File: doc/BRIEF.md
# Interrupt Priority Level Selector

This block decides, once per clock, whether a processor core should take an external interrupt and which one. Four request lines come in: device, timer, inter-processor and machine check. A 3-bit interrupt priority level and a privileged-mode flag decide which of them are allowed through. Each level allows a band of sources that grows as the level drops. The highest-ranked allowed request sets the cause code.

The result is registered. A take strobe and a cause code leave the block one cycle after the inputs that produced them. They go to an exception dispatcher together with an all-zero error code. The block keeps no memory of past requests. It evaluates the inputs again on every cycle, so the strobe stays high for as long as an allowed request is held and drops one cycle after that request goes away.

Top module: `irq_level_sel`

## Requirements
- R1: While `rst` is high, at the next rising edge `take_o` becomes 0 and `cause_o` becomes 0 (none).
- R2: When `priv_i` is 1, `take_o` is 0 one cycle later, whatever the request lines and level.
- R3: At levels 0, 1, 2 and 3 all four sources are permitted: device, timer, inter-processor and machine check.
- R4: Level 4 permits timer, inter-processor and machine check. Level 5 permits inter-processor and machine check. Level 6 permits machine check alone.
- R5: At level 7 no source is permitted, and `take_o` is 0 one cycle later.
- R6: Among permitted pending requests the winner is chosen in this order: machine check first, then inter-processor, then timer, then device. The `cause_o` encoding is 0 none, 1 device, 2 timer, 3 inter-processor, 4 machine check. `cause_o` is 0 exactly when `take_o` is 0.
- R7: `err_code_o` is all zeros at all times.
- R8: Inputs sampled at one rising edge determine `take_o`/`cause_o` right after that edge (one-cycle latency). A held permitted request keeps `take_o` high on every cycle, and `take_o` falls one cycle after the request is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req_i | input | 1 | Device interrupt request |
| tmr_req_i | input | 1 | Timer interrupt request |
| ipi_req_i | input | 1 | Inter-processor interrupt request |
| mchk_req_i | input | 1 | Machine-check request |
| ipl_i | input | 3 | Current interrupt priority level |
| priv_i | input | 1 | Privileged-mode flag; blocks all interrupts |
| take_o | output | 1 | Registered strobe: take an interrupt |
| cause_o | output | 3 | Registered cause code of the chosen source |
| err_code_o | output | 8 | Error code passed with the interrupt, always zero |

## Verification
The only state in this block is the output register. A wrong band boundary or a wrong priority order therefore shows up at the ports on the very next cycle: a strobe that should be absent appears, or a lower-ranked cause code takes the place of a higher one. Sweeping every combination of request lines, level and mode exposes such a fault within one cycle of the combination that triggers it. Holding and then dropping a request exposes a register that fails to follow its inputs, again within one cycle.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int NUM_SRC = 4;
    localparam int LVL_W   = 3;
    localparam int CAUSE_W = 3;
    localparam int ERR_W   = 8;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_DEV  = 3'd1,
        CAUSE_TMR  = 3'd2,
        CAUSE_IPI  = 3'd3,
        CAUSE_MCHK = 3'd4
    } cause_e;

    typedef struct packed {
        logic   take;
        cause_e cause;
    } pick_t;

    // Highest level at which a source (index 0 = device .. 3 = machine check) is still open.
    function automatic logic [LVL_W-1:0] src_ceiling(input int idx);
        case (idx)
            0:       return 3'd3;
            1:       return 3'd4;
            2:       return 3'd5;
            3:       return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    function automatic cause_e idx_to_cause(input int idx);
        case (idx)
            0:       return CAUSE_DEV;
            1:       return CAUSE_TMR;
            2:       return CAUSE_IPI;
            3:       return CAUSE_MCHK;
            default: return CAUSE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_sel_band.sv
module irq_sel_band
    import irq_sel_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int LW    = LVL_W
) (
    input  logic [LW-1:0]    ipl_i,
    input  logic             priv_i,
    input  logic [N_SRC-1:0] req_i,
    output logic [N_SRC-1:0] elig_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam logic [LW-1:0] CEIL = LW'(src_ceiling(g));
        assign elig_o[g] = req_i[g] && !priv_i && (ipl_i <= CEIL);
    end
endmodule

// File: rtl/irq_sel_pick.sv
module irq_sel_pick
    import irq_sel_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [N_SRC-1:0] elig_i,
    output pick_t            pick_o
);
    // Ascending scan: a higher index overrides, so it has the higher rank.
    always_comb begin
        pick_o.take  = 1'b0;
        pick_o.cause = CAUSE_NONE;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i]) begin
                pick_o.take  = 1'b1;
                pick_o.cause = idx_to_cause(i);
            end
        end
    end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
    import irq_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               dev_req_i,
    input  logic               tmr_req_i,
    input  logic               ipi_req_i,
    input  logic               mchk_req_i,
    input  logic [LVL_W-1:0]   ipl_i,
    input  logic               priv_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [ERR_W-1:0]   err_code_o
);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    logic [NUM_SRC-1:0] req_vec;
    logic [NUM_SRC-1:0] elig;
    pick_t              pick;
    pick_t              pick_q;

    assign req_vec = {mchk_req_i, ipi_req_i, tmr_req_i, dev_req_i};

    irq_sel_band #(.N_SRC(NUM_SRC), .LW(LVL_W)) u_band (
        .ipl_i  (ipl_i),
        .priv_i (priv_i),
        .req_i  (req_vec),
        .elig_o (elig)
    );

    irq_sel_pick #(.N_SRC(NUM_SRC)) u_pick (
        .elig_i (elig),
        .pick_o (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q.take  <= 1'b0;
            pick_q.cause <= CAUSE_NONE;
        end else begin
            pick_q <= pick;
        end
    end

    assign take_o     = pick_q.take;
    assign cause_o    = pick_q.cause;
    assign err_code_o = '0;

    // R2
    priv_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_i && !$past(rst)) |=> !take_o);

    // R5
    top_level_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ipl_i == LVL_MAX) |=> !take_o);

    // R6
    mchk_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (mchk_req_i && !priv_i && ipl_i != LVL_MAX) |=> (take_o && cause_o == CAUSE_MCHK));

    // R6
    cause_matches_take_chk: assert property (@(posedge clk) disable iff (rst)
        take_o == (cause_o != CAUSE_NONE));

    // R8
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vec == '0) |=> !take_o);

endmodule

// File: tb/irq_level_sel_tb.sv
module irq_level_sel_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dev_req, tmr_req, ipi_req, mchk_req;
    logic [2:0] ipl;
    logic       priv;
    logic       take;
    logic [2:0] cause;
    logic [7:0] err_code;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    irq_level_sel u_dut (
        .clk        (clk),
        .rst        (rst),
        .dev_req_i  (dev_req),
        .tmr_req_i  (tmr_req),
        .ipi_req_i  (ipi_req),
        .mchk_req_i (mchk_req),
        .ipl_i      (ipl),
        .priv_i     (priv),
        .take_o     (take),
        .cause_o    (cause),
        .err_code_o (err_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] r, input logic [2:0] l, input logic p);
        {mchk_req, ipi_req, tmr_req, dev_req} = r;
        ipl  = l;
        priv = p;
    endtask

    // Expected cause: source s (0 dev..3 mchk) open while level <= 3+s; highest s wins.
    function automatic int exp_cause(input logic [3:0] r, input int l, input logic p);
        int c = 0;
        if (p) return 0;
        for (int s = 0; s < 4; s++)
            if (r[s] && l <= 3 + s) c = s + 1;
        return c;
    endfunction

    initial begin
        drive(4'b1111, 3'd0, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset clears outputs even with requests pending
        check("R1 take", take, 0);
        check("R1 cause", cause, 0);
        rst = 1'b0;

        for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < 8; l++) begin
                for (int r = 0; r < 16; r++) begin
                    int ec;
                    string tag;
                    drive(r[3:0], l[2:0], p[0]);
                    @(posedge clk);
                    @(negedge clk);
                    ec = exp_cause(r[3:0], l, p[0]);
                    if (p != 0)      tag = "R2";
                    else if (l == 7) tag = "R5";
                    else if (l <= 3) tag = "R3";
                    else             tag = "R4";
                    check(tag, take, (ec != 0) ? 1 : 0);
                    check("R6", cause, ec);
                    check("R7", err_code, 0);
                end
            end
        end

        // R8: held timer request at level 0 keeps the strobe high every cycle
        drive(4'b0010, 3'd0, 1'b0);
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R8 held", take, 1);
        end
        // R8: machine check arrives while timer held; cause switches the next cycle
        drive(4'b1010, 3'd0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R8 switch", cause, 4);
        // R8: removing requests drops the strobe one cycle later
        drive(4'b0000, 3'd0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R8 drop", take, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule